// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt sources for a small processor core and turns them into two request lines, a high-priority one and a low-priority one, plus a wake-up line. The sources are three external pins with selectable edge polarity, a timer overflow seen on an 8-bit or 16-bit count value, a change detector on a four-bit port nibble, and a parameterized vector of level requests from peripherals. Each core source keeps a sticky flag, an enable and, where it applies, a priority bit. Each peripheral has an enable and a priority bit.

A mode bit chooses between a single-level scheme, where every enabled source goes to the high request, and a two-level scheme, where each source's priority bit picks its output. Software reaches all state through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational from the address.

External pin 0 has no priority bit and always counts as high priority. The external pins can raise the wake-up line through their own enables, whatever the global enables are set to.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Register map. Address 0 is CTRL: bit0 two-level mode, bit1 global-high enable, bit2 global-low enable (it also acts as the peripheral enable in single-level mode), bit3 16-bit timer mode. Address 1 holds the core enables: bits0-2 for pins 0-2, bit3 timer, bit4 port change. Address 2 holds the core flags in the same bit order. Address 3 holds the priorities: bit0 pin 1, bit1 pin 2, bit2 timer, bit3 port change. Address 4 holds the edge selects for pins 0-2 in bits0-2. Addresses 5 and 6 hold the enables for peripherals 0-7 and 8-15. Addresses 7 and 8 hold their priorities. Address 9 reads the synchronized port nibble in bits 7:4.
- R2: Each external pin passes through a two-stage synchronizer. A rising edge sets the pin's flag when its edge-select bit is 1, and a falling edge sets it when the bit is 0. The flag can be read back no later than four clocks after the pin changes.
- R3: A core flag stays set until software writes 0 to its bit at address 2. Writing 1 to a flag bit has no effect, and clearing the enable does not clear the flag.
- R4: In two-level mode, pin 0 with its flag and enable set always drives the high request when global-high is set, whatever the priority register holds.
- R5: In single-level mode the low request stays 0. Any enabled, flagged core source drives the high request when global-high is set. An enabled peripheral request also needs global-low set.
- R6: In two-level mode, a source whose priority bit is 1 drives the high request, gated only by global-high. A source whose priority bit is 0 drives the low request, gated only by global-low.
- R7: Any pin whose flag and enable are both set asserts wake, regardless of the global enables. A request is produced only if the matching global enable is set.
- R8: With CTRL bit3 at 0, the timer flag sets when the count's low byte goes from FFh to 00h. With bit3 at 1, it sets only when the full 16-bit count goes from FFFFh to 0000h.
- R9: The port flag sets while the synchronized nibble differs from a latched copy. The copy is updated by each read of address 9.
- R10: If a flag's set event and a software clear of that flag fall in the same cycle, the flag ends up set.
- R11: After reset, all flags, enables, edge selects and CTRL are 0, every priority bit is 1, and all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| port_pins | input | 4 | Asynchronous port nibble watched for change |
| tmr_val | input | TMR_W | Current timer count, synchronous |
| per_req | input | N_PERIPH | Level requests from peripherals |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| wake | output | 1 | Wake-up from an enabled external pin |

## Verification
A hardware flag-set event and a software write that clears the same flag can arrive on the same clock edge. The bench lines up a timer wrap so that it lands on the edge where a write to address 2 clears only the timer bit, and then reads the flag back, expecting it set. A checker property also compares every clear write against the set events of the previous cycle. A second collision mixes register writes with peripheral requests that change mid-stream. Each output is judged against a bench model after each event.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int NUM_EXT  = 3;
   localparam int NUM_CORE = 5;
   localparam int SRC_TMR  = 3;
   localparam int SRC_PORT = 4;
   localparam int NIB_W    = 4;

   typedef enum logic [3:0] {
      A_CTRL     = 4'd0,
      A_SRC_EN   = 4'd1,
      A_SRC_FLAG = 4'd2,
      A_SRC_PRIO = 4'd3,
      A_EDGE     = 4'd4,
      A_PEN_LO   = 4'd5,
      A_PEN_HI   = 4'd6,
      A_PPRI_LO  = 4'd7,
      A_PPRI_HI  = 4'd8,
      A_PORT     = 4'd9
   } reg_addr_e;
endpackage

// File: rtl/irq_edge_in.sv
module irq_edge_in #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic hit
);
   if (SYNC_STAGES < 2) begin : g_bad
      $error("irq_edge_in: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sq;
   logic                   last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq   <= '0;
         last <= 1'b0;
      end else begin
         sq   <= {sq[SYNC_STAGES-2:0], pin};
         last <= sq[SYNC_STAGES-1];
      end
   end

   assign hit = rise_sel ? (sq[SYNC_STAGES-1] & ~last)
                         : (~sq[SYNC_STAGES-1] & last);
endmodule

// File: rtl/irq_nibble_watch.sv
module irq_nibble_watch #(
   parameter int W           = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] port_in,
   input  logic         snap,
   output logic [W-1:0] cur,
   output logic         changed
);
   if (SYNC_STAGES < 2) begin : g_bad
      $error("irq_nibble_watch: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] sq [SYNC_STAGES];
   logic [W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) sq[s] <= '0;
         held <= '0;
      end else begin
         sq[0] <= port_in;
         for (int s = 1; s < SYNC_STAGES; s++) sq[s] <= sq[s-1];
         if (snap) held <= sq[SYNC_STAGES-1];
      end
   end

   assign cur     = sq[SYNC_STAGES-1];
   assign changed = (sq[SYNC_STAGES-1] != held);
endmodule

// File: rtl/irq_tmr_wrap.sv
module irq_tmr_wrap #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wide,
   output logic             wrap
);
   localparam int HALF = CNT_W / 2;

   if (CNT_W < 2 || (CNT_W % 2) != 0) begin : g_bad
      $error("irq_tmr_wrap: CNT_W must be even and at least 2");
   end

   logic [CNT_W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cnt;
   end

   assign wrap = wide ? ((&prev) && (cnt == '0))
                      : ((&prev[HALF-1:0]) && (cnt[HALF-1:0] == '0));
endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int N_CORE = 5,
   parameter int N_PER  = 16
) (
   input  logic              two_level,
   input  logic              g_hi,
   input  logic              g_lo,
   input  logic [N_CORE-1:0] core_act,
   input  logic [N_CORE-1:0] core_hi,
   input  logic [N_PER-1:0]  per_act,
   input  logic [N_PER-1:0]  per_hi,
   output logic              req_hi,
   output logic              req_lo
);
   logic hi_any, lo_any;

   always_comb begin
      hi_any = (|(core_act & core_hi))  | (|(per_act & per_hi));
      lo_any = (|(core_act & ~core_hi)) | (|(per_act & ~per_hi));
      if (two_level) begin
         req_hi = g_hi & hi_any;
         req_lo = g_lo & lo_any;
      end else begin
         req_hi = g_hi & ((|core_act) | (g_lo & (|per_act)));
         req_lo = 1'b0;
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_PERIPH    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TMR_W       = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          ext_pin,
   input  logic [3:0]          port_pins,
   input  logic [TMR_W-1:0]    tmr_val,
   input  logic [N_PERIPH-1:0] per_req,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [3:0]          reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   output logic                irq_hi,
   output logic                irq_lo,
   output logic                wake
);
   import prio_irq_pkg::*;

   localparam int PAD_W = 16;

   if (N_PERIPH < 1 || N_PERIPH > PAD_W) begin : g_bad_per
      $error("prio_irq_ctrl: N_PERIPH must be 1..16");
   end

   logic [3:0]          ctrl_q;
   logic [NUM_CORE-1:0] src_en_q, flag_q, set_vec, clr_vec;
   logic [3:0]          src_pri_q;
   logic [NUM_EXT-1:0]  edge_q, ext_hit;
   logic [N_PERIPH-1:0] per_en, per_pri;
   logic [PAD_W-1:0]    pen_pad, ppr_pad;
   logic [NIB_W-1:0]    nib_cur;
   logic                nib_chg, tmr_hit;

   wire two_level = ctrl_q[0];
   wire g_hi      = ctrl_q[1];
   wire g_lo      = ctrl_q[2];
   wire tmr_wide  = ctrl_q[3];
   wire wr_hit_flag = reg_wr && (reg_addr == A_SRC_FLAG);

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      irq_edge_in #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk(clk), .rst_n(rst_n), .pin(ext_pin[e]),
         .rise_sel(edge_q[e]), .hit(ext_hit[e]));
   end

   irq_tmr_wrap #(.CNT_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cnt(tmr_val), .wide(tmr_wide), .wrap(tmr_hit));

   irq_nibble_watch #(.W(NIB_W), .SYNC_STAGES(SYNC_STAGES)) u_nib (
      .clk(clk), .rst_n(rst_n), .port_in(port_pins),
      .snap(reg_rd && (reg_addr == A_PORT)),
      .cur(nib_cur), .changed(nib_chg));

   assign set_vec = {nib_chg, tmr_hit, ext_hit};
   assign clr_vec = wr_hit_flag ? ~reg_wdata[NUM_CORE-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         src_en_q  <= '0;
         flag_q    <= '0;
         src_pri_q <= '1;
         edge_q    <= '0;
      end else begin
         flag_q <= (flag_q & ~clr_vec) | set_vec;
         if (reg_wr) begin
            case (reg_addr)
               A_CTRL:     ctrl_q    <= reg_wdata[3:0];
               A_SRC_EN:   src_en_q  <= reg_wdata[NUM_CORE-1:0];
               A_SRC_PRIO: src_pri_q <= reg_wdata[3:0];
               A_EDGE:     edge_q    <= reg_wdata[NUM_EXT-1:0];
               default: ;
            endcase
         end
      end
   end

   for (genvar i = 0; i < N_PERIPH; i++) begin : g_per
      localparam int BANK = i / 8;
      localparam int BIT  = i % 8;
      logic en_q, pr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q <= 1'b0;
            pr_q <= 1'b1;
         end else if (reg_wr) begin
            if (reg_addr == ((BANK == 0) ? A_PEN_LO : A_PEN_HI))
               en_q <= reg_wdata[BIT];
            if (reg_addr == ((BANK == 0) ? A_PPRI_LO : A_PPRI_HI))
               pr_q <= reg_wdata[BIT];
         end
      end
      assign per_en[i]  = en_q;
      assign per_pri[i] = pr_q;
   end

   for (genvar i = 0; i < PAD_W; i++) begin : g_pad
      if (i < N_PERIPH) begin : g_used
         assign pen_pad[i] = per_en[i];
         assign ppr_pad[i] = per_pri[i];
      end else begin : g_zero
         assign pen_pad[i] = 1'b0;
         assign ppr_pad[i] = 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:     reg_rdata = {4'b0, ctrl_q};
         A_SRC_EN:   reg_rdata = {3'b0, src_en_q};
         A_SRC_FLAG: reg_rdata = {3'b0, flag_q};
         A_SRC_PRIO: reg_rdata = {4'b0, src_pri_q};
         A_EDGE:     reg_rdata = {5'b0, edge_q};
         A_PEN_LO:   reg_rdata = pen_pad[7:0];
         A_PEN_HI:   reg_rdata = pen_pad[15:8];
         A_PPRI_LO:  reg_rdata = ppr_pad[7:0];
         A_PPRI_HI:  reg_rdata = ppr_pad[15:8];
         A_PORT:     reg_rdata = {nib_cur, 4'b0};
         default:    reg_rdata = '0;
      endcase
   end

   irq_route #(.N_CORE(NUM_CORE), .N_PER(N_PERIPH)) u_route (
      .two_level(two_level), .g_hi(g_hi), .g_lo(g_lo),
      .core_act(flag_q & src_en_q),
      .core_hi({src_pri_q, 1'b1}),
      .per_act(per_req & per_en),
      .per_hi(per_pri),
      .req_hi(irq_hi), .req_lo(irq_lo));

   assign wake = |(flag_q[NUM_EXT-1:0] & src_en_q[NUM_EXT-1:0]);
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [3:0] reg_addr,
   input logic [4:0] flag_q,
   input logic [4:0] set_vec,
   input logic [2:0] ext_en,
   input logic       two_level,
   input logic       g_hi,
   input logic       irq_hi,
   input logic       irq_lo,
   input logic       wake
);
   AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == 4'd2) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R3
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 4'd2) |=> ((flag_q & $past(set_vec)) == $past(set_vec))); // R10
   AST_LO_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !two_level |-> !irq_lo); // R5
   AST_PIN0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (two_level && g_hi && flag_q[0] && ext_en[0]) |-> irq_hi); // R4
   AST_WAKE_ANY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flag_q[2:0] & ext_en)) |-> wake); // R7
   AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flag_q[2:0] & ext_en)) |-> !wake); // R7
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .flag_q(flag_q), .set_vec(set_vec), .ext_en(src_en_q[2:0]),
   .two_level(ctrl_q[0]), .g_hi(ctrl_q[1]),
   .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake));

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  ext_pin = '0;
   logic [3:0]  port_pins = '0;
   logic [15:0] tmr_val = '0;
   logic [NP-1:0] per_req = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq_hi, irq_lo, wake;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [3:0]  sh_ctrl = '0, sh_pri = 4'hF;
   logic [4:0]  sh_en = '0, sh_flg = '0;
   logic [15:0] sh_pen = '0, sh_ppr = 16'hFFFF;

   prio_irq_ctrl #(.N_PERIPH(NP), .SYNC_STAGES(2), .TMR_W(16)) u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
      .tmr_val(tmr_val), .per_req(per_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [2:0] model();
      logic [4:0] ca;
      logic [15:0] pa;
      logic [4:0] chi;
      logic h, l, w;
      ca  = sh_flg & sh_en;
      pa  = per_req & sh_pen;
      chi = {sh_pri, 1'b1};
      if (sh_ctrl[0]) begin
         h = sh_ctrl[1] & ((|(ca & chi))  | (|(pa & sh_ppr)));
         l = sh_ctrl[2] & ((|(ca & ~chi)) | (|(pa & ~sh_ppr)));
      end else begin
         h = sh_ctrl[1] & ((|ca) | (sh_ctrl[2] & (|pa)));
         l = 1'b0;
      end
      w = |ca[2:0];
      return {h, l, w};
   endfunction

   task automatic check_outs(input string tag);
      logic [2:0] e;
      e = model();
      chk({tag, " irq_hi"}, 16'(irq_hi), 16'(e[2]));
      chk({tag, " irq_lo"}, 16'(irq_lo), 16'(e[1]));
      chk({tag, " wake"},   16'(wake),   16'(e[0]));
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      case (a)
         4'd0: sh_ctrl = d[3:0];
         4'd1: sh_en = d[4:0];
         4'd2: sh_flg = sh_flg & d[4:0];
         4'd3: sh_pri = d[3:0];
         4'd5: sh_pen[7:0] = d;
         4'd6: sh_pen[15:8] = d;
         4'd7: sh_ppr[7:0] = d;
         4'd8: sh_ppr[15:8] = d;
         default: ;
      endcase
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic pin(input int idx, input logic v);
      @(negedge clk);
      ext_pin[idx] = v;
      repeat (4) @(posedge clk);
   endtask

   task automatic tmr_step(input logic [15:0] v);
      @(negedge clk);
      tmr_val = v;
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R11 reset state
      @(negedge clk);
      chk("R11 irq_hi", 16'(irq_hi), 0);
      chk("R11 irq_lo", 16'(irq_lo), 0);
      chk("R11 wake", 16'(wake), 0);
      rd(4'd3, d); chk("R11 prio", 16'(d), 16'h0F);
      rd(4'd2, d); chk("R11 flags", 16'(d), 0);
      rd(4'd0, d); chk("R1 R11 ctrl", 16'(d), 0);
      rd(4'd7, d); chk("R11 per prio", 16'(d), 16'hFF);

      // R2 edge polarity: pin0 rise, pin1 fall, pin2 rise
      wr(4'd4, 8'h05);
      pin(1, 1'b1);
      rd(4'd2, d); chk("R2 rise ignored on fall-select", 16'(d), 0);
      pin(1, 1'b0);
      rd(4'd2, d); chk("R2 fall sets pin1", 16'(d), 16'h02);
      pin(0, 1'b1);
      pin(2, 1'b1);
      rd(4'd2, d); chk("R2 rise sets pin0 pin2", 16'(d), 16'h07);
      sh_flg = 5'h07;

      // R7 wake without globals
      wr(4'd1, 8'h02);
      @(negedge clk); check_outs("R7 globals off");
      chk("R7 wake asserted", 16'(wake), 1);
      wr(4'd0, 8'h02);
      @(negedge clk); check_outs("R7 global high on");

      // R3 sticky flags
      wr(4'd1, 8'h00);
      rd(4'd2, d); chk("R3 enable clear keeps flag", 16'(d), 16'h07);
      wr(4'd2, 8'hFF);
      rd(4'd2, d); chk("R3 write one no effect", 16'(d), 16'h07);
      wr(4'd2, 8'hFE);
      rd(4'd2, d); chk("R3 write zero clears", 16'(d), 16'h06);

      // R4 R6 two-level routing
      wr(4'd0, 8'h03);
      wr(4'd3, 8'h0E);
      wr(4'd1, 8'h02);
      @(negedge clk); check_outs("R6 low source, global-low off");
      chk("R6 lo held off", 16'(irq_lo), 0);
      wr(4'd0, 8'h07);
      @(negedge clk); check_outs("R6 low source, global-low on");
      chk("R6 lo asserted", 16'(irq_lo), 1);
      pin(0, 1'b0);
      pin(0, 1'b1);
      sh_flg[0] = 1'b1;
      wr(4'd3, 8'h00);
      wr(4'd1, 8'h01);
      @(negedge clk); check_outs("R4 pin0 with prio zeros");
      chk("R4 pin0 high", 16'(irq_hi), 1);

      // R8 timer wrap
      wr(4'd0, 8'h00); wr(4'd1, 8'h00);
      wr(4'd2, 8'h00);
      tmr_step(16'h12FF); tmr_step(16'h1300);
      rd(4'd2, d); chk("R8 8-bit wrap", 16'(d[3]), 1);
      wr(4'd2, 8'h00);
      wr(4'd0, 8'h08);
      tmr_step(16'h00FF); tmr_step(16'h0100);
      rd(4'd2, d); chk("R8 16-bit ignores byte wrap", 16'(d[3]), 0);
      tmr_step(16'hFFFF); tmr_step(16'h0000);
      rd(4'd2, d); chk("R8 16-bit wrap", 16'(d[3]), 1);
      wr(4'd0, 8'h00);
      wr(4'd2, 8'h00);

      // R10 set beats clear on the same edge
      tmr_step(16'h00FF);
      @(negedge clk);
      tmr_val = 16'h0100;
      reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 8'hF7;
      @(posedge clk); #1 reg_wr = 1'b0;
      rd(4'd2, d); chk("R10 set wins", 16'(d[3]), 1);
      wr(4'd2, 8'hF7);
      rd(4'd2, d); chk("R10 later clear works", 16'(d[3]), 0);
      sh_flg = '0;

      // R9 port change
      @(negedge clk) port_pins = 4'hA;
      repeat (4) @(posedge clk);
      rd(4'd2, d); chk("R9 change flag", 16'(d[4]), 1);
      rd(4'd9, d); chk("R9 port read", 16'(d[7:4]), 16'hA);
      wr(4'd2, 8'hEF);
      rd(4'd2, d); chk("R9 cleared after latch", 16'(d[4]), 0);
      sh_flg = '0;

      // R5 single level peripheral gating
      wr(4'd0, 8'h02); wr(4'd1, 8'h00); wr(4'd5, 8'h20);
      @(negedge clk) per_req = 16'h0020;
      #1 check_outs("R5 peripheral without global-low");
      chk("R5 hi off", 16'(irq_hi), 0);
      wr(4'd0, 8'h06);
      @(negedge clk); check_outs("R5 peripheral with global-low");
      chk("R5 hi on", 16'(irq_hi), 1);

      // re-arm core flags for random phase
      wr(4'd4, 8'h07);
      pin(0, 1'b0); pin(0, 1'b1);
      pin(1, 1'b1); pin(2, 1'b0); pin(2, 1'b1);
      tmr_step(16'h00FF); tmr_step(16'h0100);
      @(negedge clk) port_pins = 4'h5;
      repeat (4) @(posedge clk);
      rd(4'd9, d);
      sh_flg = 5'h1F;

      // R5 R6 R7 random mix
      for (int it = 0; it < 300; it++) begin
         int op;
         logic [7:0] v;
         op = int'($urandom % 8);
         v  = 8'($urandom);
         case (op)
            0: wr(4'd0, {4'b0, v[3:0]});
            1: wr(4'd1, v);
            2: wr(4'd3, v);
            3: wr(4'd5, v);
            4: wr(4'd6, v);
            5: wr(4'd7, v);
            6: wr(4'd8, v);
            default: if (v[7:5] == 3'b000) wr(4'd2, {3'b111, v[4:0] | 5'h18});
         endcase
         @(negedge clk) per_req = 16'($urandom);
         #1 check_outs(sh_ctrl[0] ? "R6 random" : "R5 random");
      end

      finish_run();
   end
endmodule